// File: doc/BRIEF.md
# Per-Line Pedestal Gate for 525-Line Video

This block decides, once per video line, whether the black-level setup (the pedestal) is added to the picture signal. A timing generator supplies a line-start strobe, the current line number and a flag saying which field is being scanned. The block combines these with a bank of software-written control bits and produces one flag, `pedOn`, that the level arithmetic downstream uses for the whole line.

In each field, sixteen lines of the vertical blanking interval can be controlled one by one. In the first field these are lines 10 to 25. In the second field they are lines 273 to 288. Each of these lines has its own control bit. Every other line follows a single global enable bit. Software writes the control bits through a byte-wide address and strobe port. A write takes effect at the next line start, so a line never changes its level partway through. When the standard-select input says the output is PAL, the block forces the pedestal off.

Top module: `ped_line_gate`

## Requirements
- R1: After reset, `pedOn` is 0, every per-line control bit is 0 and the global enable is 1.
- R2: For a line start with `fieldSecond`=0 and `lineNum` from 10 to 25, `pedOn` becomes the inverse of the per-line bit for that line. Address 0 bit i controls line 10+i, address 1 bit i controls line 18+i, and a bit value of 1 means the pedestal is off.
- R3: For a line start with `fieldSecond`=1 and `lineNum` from 273 to 288, `pedOn` becomes the inverse of the per-line bit for that line. Address 2 bit i controls line 273+i and address 3 bit i controls line 281+i.
- R4: For any other line, `pedOn` becomes the global enable, which is bit 0 of address 4. This includes the range boundaries 9, 26, 272 and 289.
- R5: The field flag selects which range applies. Line 10 with `fieldSecond`=1 and line 273 with `fieldSecond`=0 both follow the global enable.
- R6: `pedOn` changes only in the cycle after a `lineStart` strobe and holds its value until the next strobe, even when registers are written in between.
- R7: A write is used from the next line start onward. A write in the same cycle as `lineStart` does not affect that line.
- R8: A line that starts while `palMode`=1 has `pedOn`=0, whatever the register contents.
- R9: Writes to addresses 5 to 7 change nothing, and bits 7:1 of address 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| lineNum | input | 10 | Line number within the frame, valid with `lineStart` |
| fieldSecond | input | 1 | 1 while the second field is scanned |
| palMode | input | 1 | 1 selects PAL, which forces the pedestal off |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0-3 per-line bytes, 4 global enable) |
| wrData | input | 8 | Register write data |
| pedOn | output | 1 | Pedestal enable for the current line |

## Verification
The assertions check the following on every cycle:
- `pedOn` stays constant between line starts.
- A PAL line never carries a pedestal.
- The address decode raises at most one write strobe, and only while `wrEn` is high.
- Each line-start decision matches the bank bit or the global bit it was steered to.

Some properties can only be shown by the bench's scenarios:
- The mapping from address and bit position to a physical line.
- The exact range boundaries, and the field-dependent choice between the two ranges.
- The ordering of a write against a line start in the same cycle.
- That writes to unused addresses leave the bank unchanged.

// File: rtl/ped_pkg.sv
package ped_pkg;
  // Lines per field that can be controlled one by one (power of two)
  localparam int PED_SPAN   = 16;
  // Width of one control register
  localparam int PED_REG_W  = 8;
  localparam int PED_BANK_W = 2 * PED_SPAN;
  localparam int PED_NREGS  = PED_BANK_W / PED_REG_W;
  localparam int PED_IDX_W  = $clog2(PED_BANK_W);
  localparam int PED_ADDR_W = $clog2(PED_NREGS + 1);

  // Strobes and steering from the control side to the datapath
  typedef struct packed {
    logic                 lineStart;
    logic [PED_NREGS-1:0] wrReg;
    logic                 wrGlobal;
    logic                 inRange;
    logic [PED_IDX_W-1:0] bitIdx;
    logic                 forceOff;
  } pedCtrl_t;
endpackage

// File: rtl/ped_ctrl.sv
module ped_ctrl
  import ped_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int F0_FIRST = 10,
  parameter int F1_FIRST = 273
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lineStart,
  input  logic [LINE_W-1:0]     lineNum,
  input  logic                  fieldSecond,
  input  logic                  palMode,
  input  logic                  wrEn,
  input  logic [PED_ADDR_W-1:0] wrAddr,
  output pedCtrl_t              ctrl
);
  localparam int OFF_IDX_W = PED_IDX_W - 1;

  logic [LINE_W-1:0] offset;
  logic [PED_NREGS-1:0] regHit;

  // Offset from the first controllable line of the current field;
  // lines below it wrap to large values and fall out of range.
  always_comb begin
    if (fieldSecond) offset = lineNum - LINE_W'(F1_FIRST);
    else             offset = lineNum - LINE_W'(F0_FIRST);
  end

  for (genvar g = 0; g < PED_NREGS; g++) begin : g_dec
    assign regHit[g] = wrEn && (wrAddr == PED_ADDR_W'(g));
  end

  always_comb begin
    ctrl.lineStart = lineStart;
    ctrl.wrReg     = regHit;
    ctrl.wrGlobal  = wrEn && (wrAddr == PED_ADDR_W'(PED_NREGS));
    ctrl.inRange   = offset < LINE_W'(PED_SPAN);
    ctrl.bitIdx    = {fieldSecond, offset[OFF_IDX_W-1:0]};
    ctrl.forceOff  = palMode;
  end

  // R9: at most one register selected per write
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.wrReg, ctrl.wrGlobal}));

  // R9: no strobe without a write request
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (ctrl.wrReg == '0) && !ctrl.wrGlobal);
endmodule

// File: rtl/ped_dp.sv
module ped_dp
  import ped_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pedCtrl_t             ctrl,
  input  logic [PED_REG_W-1:0] wrData,
  output logic                 pedOn
);
  logic [PED_BANK_W-1:0] bank;
  logic                  globalEn;
  logic                  lineBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank     <= '0;
      globalEn <= 1'b1;
    end else begin
      for (int g = 0; g < PED_NREGS; g++) begin
        if (ctrl.wrReg[g]) bank[g*PED_REG_W +: PED_REG_W] <= wrData;
      end
      if (ctrl.wrGlobal) globalEn <= wrData[0];
    end
  end

  assign lineBit = bank[ctrl.bitIdx];

  // Decision taken from the register state before any write in the
  // same cycle, then held for the whole line
  always_ff @(posedge clk) begin
    if (!rstN)               pedOn <= 1'b0;
    else if (ctrl.lineStart) pedOn <= !ctrl.forceOff &&
                                      (ctrl.inRange ? !lineBit : globalEn);
  end

  // R6: level held between line starts
  a_r6_hold_line: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.lineStart |=> $stable(pedOn));

  // R8: PAL line never carries a pedestal
  a_r8_pal_off: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lineStart && ctrl.forceOff |=> !pedOn);

  // R4: out-of-range line follows the global enable
  a_r4_global: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lineStart && !ctrl.forceOff && !ctrl.inRange
      |=> pedOn == $past(globalEn));

  // R2: controllable line follows its bank bit, inverted
  a_r2_line_bit: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lineStart && !ctrl.forceOff && ctrl.inRange
      |=> pedOn != $past(lineBit));
endmodule

// File: rtl/ped_line_gate.sv
module ped_line_gate
  import ped_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int F0_FIRST = 10,
  parameter int F1_FIRST = 273
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lineStart,
  input  logic [LINE_W-1:0]     lineNum,
  input  logic                  fieldSecond,
  input  logic                  palMode,
  input  logic                  wrEn,
  input  logic [PED_ADDR_W-1:0] wrAddr,
  input  logic [PED_REG_W-1:0]  wrData,
  output logic                  pedOn
);
  pedCtrl_t ctrl;

  ped_ctrl #(
    .LINE_W  (LINE_W),
    .F0_FIRST(F0_FIRST),
    .F1_FIRST(F1_FIRST)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .lineNum    (lineNum),
    .fieldSecond(fieldSecond),
    .palMode    (palMode),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .ctrl       (ctrl)
  );

  ped_dp i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .wrData(wrData),
    .pedOn (pedOn)
  );
endmodule

// File: tb/test_ped_line_gate.sv
module test_ped_line_gate;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic [9:0] lineNum = '0;
  logic       fieldSecond = 1'b0;
  logic       palMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pedOn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ped_line_gate i_ped_line_gate (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineNum(lineNum),
    .fieldSecond(fieldSecond), .palMode(palMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pedOn(pedOn)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pedOn=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Start a line, then sample one cycle later at the falling edge
  task automatic startLine(input int ln, input logic fld, input logic pal,
                           input string req, input logic exp);
    @(negedge clk);
    lineStart = 1'b1; lineNum = 10'(ln); fieldSecond = fld; palMode = pal;
    @(negedge clk);
    lineStart = 1'b0;
    check(req, pedOn, exp);
  endtask

  task automatic testReset();
    check("R1 reset output", pedOn, 1'b0);
    startLine(5, 0, 0, "R1 global default", 1'b1);
    startLine(17, 0, 0, "R1 bank default", 1'b1);
  endtask

  task automatic testFirstField();
    writeReg(3'd0, 8'h01);
    writeReg(3'd1, 8'h80);
    startLine(10, 0, 0, "R2 line 10 off", 1'b0);
    startLine(11, 0, 0, "R2 line 11 on", 1'b1);
    startLine(25, 0, 0, "R2 line 25 off", 1'b0);
    startLine(24, 0, 0, "R2 line 24 on", 1'b1);
    startLine(9, 0, 0, "R4 line 9 global", 1'b1);
    startLine(26, 0, 0, "R4 line 26 global", 1'b1);
  endtask

  task automatic testSecondField();
    writeReg(3'd2, 8'h01);
    writeReg(3'd3, 8'h80);
    startLine(273, 1, 0, "R3 line 273 off", 1'b0);
    startLine(274, 1, 0, "R3 line 274 on", 1'b1);
    startLine(288, 1, 0, "R3 line 288 off", 1'b0);
    startLine(272, 1, 0, "R4 line 272 global", 1'b1);
    startLine(289, 1, 0, "R4 line 289 global", 1'b1);
    startLine(10, 1, 0, "R5 line 10 in field 2", 1'b1);
    startLine(273, 0, 0, "R5 line 273 in field 1", 1'b1);
  endtask

  task automatic testGlobal();
    writeReg(3'd4, 8'h00);
    startLine(5, 0, 0, "R4 global off", 1'b0);
    startLine(11, 0, 0, "R2 bank overrides global", 1'b1);
    startLine(10, 1, 0, "R5 field 2 line 10 global off", 1'b0);
    writeReg(3'd4, 8'hFE);
    startLine(5, 0, 0, "R9 upper bits ignored", 1'b0);
    writeReg(3'd4, 8'h01);
    startLine(5, 0, 0, "R4 global on again", 1'b1);
  endtask

  task automatic testUnusedAddr();
    writeReg(3'd5, 8'h00);
    writeReg(3'd6, 8'hFF);
    writeReg(3'd7, 8'hFE);
    startLine(10, 0, 0, "R9 bank byte 0 untouched", 1'b0);
    startLine(11, 0, 0, "R9 bank bit 1 untouched", 1'b1);
    startLine(5, 0, 0, "R9 global untouched", 1'b1);
  endtask

  task automatic testWriteTiming();
    // Write in the same cycle as the line start: not used for this line
    @(negedge clk);
    lineStart = 1'b1; lineNum = 10'd12; fieldSecond = 1'b0; palMode = 1'b0;
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h05;
    @(negedge clk);
    lineStart = 1'b0; wrEn = 1'b0;
    check("R7 same-cycle write unseen", pedOn, 1'b1);
    // Write mid-line: the level is held
    writeReg(3'd0, 8'h01);
    check("R6 held across write", pedOn, 1'b1);
    repeat (3) @(negedge clk);
    check("R6 held over idle cycles", pedOn, 1'b1);
    writeReg(3'd0, 8'h04);
    startLine(12, 0, 0, "R7 write used next line", 1'b0);
    startLine(10, 0, 0, "R7 line 10 now on", 1'b1);
  endtask

  task automatic testPal();
    startLine(11, 0, 1, "R8 PAL controllable line", 1'b0);
    startLine(5, 0, 1, "R8 PAL global line", 1'b0);
    startLine(280, 1, 1, "R8 PAL field 2", 1'b0);
    startLine(5, 0, 0, "R8 back to NTSC", 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFirstField();
    testSecondField();
    testGlobal();
    testUnusedAddr();
    testWriteTiming();
    testPal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule